// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This block runs once at start-up, before any data is written, and finds the blocks that the factory marked as unusable. Starting from block zero and going upward, it asks the NAND host sequencer for one byte from each block. That byte is the first spare byte of page 0, at column 2048. The sequencer produces it with a page read and, if needed, a random data read of that column. The scanner treats a block as unusable in two cases: the byte comes back as zero, or the sequencer reports an error or a timeout for that block. The result of each block goes into a bitmap with one bit per block, and a bad-block tally is kept alongside it.

When the scan ends, the scanner pulses a done strobe. After that, a host can look up any block index and read back its bad bit one cycle later. The scanner also guards erase requests on their way to the sequencer. An erase is refused if it targets a block marked bad, because erasing that block would destroy its marker. An erase is also refused while the table is not yet trustworthy: before the first scan completes, and while a scan is running.

Top module: `bbscan_top`

## Requirements
- R1: After reset the busy, done, request-valid, erase-pass and overflow outputs are 0 and the bad count is 0.
- R2: A scan issues exactly one read request per block, in ascending block order. Each request carries row = block index shifted left by 6 (page 0 of that block) and column = 2048. The row and the valid signal are held steady until the ready input is seen high.
- R3: A response byte of 00h marks the block bad (bitmap bit 1). Any nonzero byte without an error marks it good (bit 0).
- R4: A response that carries the error flag marks the block bad, whatever its data byte.
- R5: Starting a scan clears the whole bitmap and the count. The lookup port returns the bit of the presented index on the clock edge that follows.
- R6: The bad count stops at 40. When a further bad block is found while the count is already 40, the overflow flag is set. Exactly 40 bad blocks leave the flag at 0.
- R7: Done is high for exactly one cycle, in the cycle after the last block's response is taken. Busy is low from that cycle on, and the count and flag are final at that point.
- R8: After a completed scan, an erase request for a bad block gives reject=1 and pass=0. One for a good block gives pass=1 and reject=0, in the same cycle. With no request, both are 0.
- R9: Erase requests are rejected before the first scan completes and while a scan is running.
- R10: A start pulse while a scan is running is ignored. The walk continues without restarting.
- R11: If a lookup targets the block whose result is being recorded in the same cycle, it returns the bit from before that write. The next lookup returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_start_i | input | 1 | Start a scan (taken only when idle) |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | One-cycle pulse when the scan ends |
| rd_req_valid_o | output | 1 | Marker read request valid |
| rd_req_ready_i | input | 1 | Sequencer accepts the request |
| rd_req_row_o | output | 17 | Row address (block, page 0) |
| rd_req_col_o | output | 12 | Column address of the marker byte |
| rd_rsp_valid_i | input | 1 | Response valid |
| rd_rsp_data_i | input | 8 | Marker byte returned |
| rd_rsp_err_i | input | 1 | Sequencer error or timeout for this read |
| lk_blk_i | input | 11 | Block index to look up |
| lk_bad_o | output | 1 | Bad bit of the looked-up block (one cycle later) |
| bad_count_o | output | 6 | Saturating bad-block count |
| bad_ovf_o | output | 1 | More bad blocks than the limit were found |
| er_valid_i | input | 1 | Erase request valid |
| er_blk_i | input | 11 | Block targeted by the erase |
| er_pass_o | output | 1 | Erase may be forwarded |
| er_reject_o | output | 1 | Erase refused |

## Verification
Two functions can fall in the same clock edge. One is the recording of a block's verdict into the bitmap. The other is a host lookup of that same block. The bench's sequencer model provokes this by steering the lookup index onto a bad block at the moment it delivers that block's response. It then expects the old value 0 on the first sampled lookup and 1 on the next. A second overlap is an erase request or a fresh start pulse arriving in the middle of a running walk. These are judged by the erase being refused, by the request order staying strictly ascending, and by the final tally matching.

// File: rtl/bbscan_pkg.sv
// Package: shared types of the bad-block scanner.
// Assumes: nothing beyond IEEE 1800-2017.
package bbscan_pkg;

    // Walker states: idle, request outstanding, waiting for the marker byte.
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_REQ  = 2'd1,
        SC_WAIT = 2'd2
    } scan_state_t;

endpackage

// File: rtl/bbscan_walker.sv
// Module: bbscan_walker
// Walks every block in ascending order. For each block it issues one marker-read
// request (page 0, marker column) and classifies the returned byte.
// Assumes: the sequencer answers each accepted request with exactly one
// response, and no response arrives without a request.
module bbscan_walker
    import bbscan_pkg::*;
#(
    parameter int NUM_BLOCKS = 2048,
    parameter int PAGE_BITS  = 6,
    parameter int COL_W      = 12,
    parameter int MARKER_COL = 2048,
    parameter int DATA_W     = 8,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ROW_W     = BLK_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              scanned_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ROW_W-1:0]  req_row_o,
    output logic [COL_W-1:0]  req_col_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              rsp_err_i,
    output logic              clr_o,
    output logic              wr_en_o,
    output logic [BLK_W-1:0]  wr_idx_o,
    output logic              wr_bad_o
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_t      state_q;
    logic [BLK_W-1:0] blk_q;
    logic             done_q;
    logic             scanned_q;
    logic             last_rec;

    // Derive request, table-write and clear strobes from the current state.
    always_comb begin
        clr_o       = (state_q == SC_IDLE) && start_i;
        req_valid_o = (state_q == SC_REQ);
        req_row_o   = {blk_q, {PAGE_BITS{1'b0}}};
        req_col_o   = COL_W'(MARKER_COL);
        wr_en_o     = (state_q == SC_WAIT) && rsp_valid_i;
        wr_idx_o    = blk_q;
        wr_bad_o    = rsp_err_i || (rsp_data_i == '0);
        last_rec    = wr_en_o && (blk_q == LAST_BLK);
    end

    // Advance the walk: accept start, hand off request, record response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            blk_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SC_IDLE: begin
                    if (start_i) begin
                        blk_q   <= '0;
                        state_q <= SC_REQ;
                    end
                end
                SC_REQ: begin
                    if (req_ready_i) begin
                        state_q <= SC_WAIT;
                    end
                end
                SC_WAIT: begin
                    if (rsp_valid_i) begin
                        if (blk_q == LAST_BLK) begin
                            state_q <= SC_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            blk_q   <= blk_q + 1'b1;
                            state_q <= SC_REQ;
                        end
                    end
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    // Track whether a full walk has finished since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scanned_q <= 1'b0;
        end else if (clr_o) begin
            scanned_q <= 1'b0;
        end else if (last_rec) begin
            scanned_q <= 1'b1;
        end
    end

    assign busy_o    = (state_q != SC_IDLE);
    assign done_o    = done_q;
    assign scanned_o = scanned_q;

endmodule

// File: rtl/bbscan_bitmap.sv
// Module: bbscan_bitmap
// One bit per block: a write port from the walker, a registered lookup port,
// and a combinational port for the erase guard.
// Assumes: clear and write never coincide (the walker guarantees this).
module bbscan_bitmap #(
    parameter int NUM_BLOCKS = 2048,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [BLK_W-1:0] wr_idx_i,
    input  logic             wr_bad_i,
    input  logic [BLK_W-1:0] lk_idx_i,
    output logic             lk_bad_o,
    input  logic [BLK_W-1:0] er_idx_i,
    output logic             er_bad_o
);

    logic [NUM_BLOCKS-1:0] bits_q;
    logic                  lk_q;

    // Hold the per-block verdicts; cleared by reset or by a new scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (clr_i) begin
            bits_q <= '0;
        end else if (wr_en_i) begin
            bits_q[wr_idx_i] <= wr_bad_i;
        end
    end

    // Register the lookup result (pre-write contents of this edge).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= 1'b0;
        end else begin
            lk_q <= bits_q[lk_idx_i];
        end
    end

    assign lk_bad_o = lk_q;
    assign er_bad_o = bits_q[er_idx_i];

endmodule

// File: rtl/bbscan_tally.sv
// Module: bbscan_tally
// Counts bad verdicts up to a limit and raises a sticky overflow flag once
// a verdict arrives beyond it.
// Assumes: at most one increment per cycle.
module bbscan_tally #(
    parameter int MAX_BAD = 40,
    localparam int CNT_W  = $clog2(MAX_BAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Saturating count with overflow capture; cleared at scan start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (inc_i) begin
            if (cnt_q == LIMIT) begin
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/bbscan_top.sv
// Module: bbscan_top
// Factory bad-block scanner: walker + bitmap + tally, plus an erase guard
// that refuses erases of marked blocks or while the table is not valid.
// Assumes: a single NAND sequencer on the request/response port.
module bbscan_top #(
    parameter int NUM_BLOCKS = 2048,
    parameter int PAGE_BITS  = 6,
    parameter int COL_W      = 12,
    parameter int MARKER_COL = 2048,
    parameter int DATA_W     = 8,
    parameter int MAX_BAD    = 40,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int ROW_W     = BLK_W + PAGE_BITS,
    localparam int CNT_W     = $clog2(MAX_BAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_start_i,
    output logic              scan_busy_o,
    output logic              scan_done_o,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ROW_W-1:0]  rd_req_row_o,
    output logic [COL_W-1:0]  rd_req_col_o,
    input  logic              rd_rsp_valid_i,
    input  logic [DATA_W-1:0] rd_rsp_data_i,
    input  logic              rd_rsp_err_i,
    input  logic [BLK_W-1:0]  lk_blk_i,
    output logic              lk_bad_o,
    output logic [CNT_W-1:0]  bad_count_o,
    output logic              bad_ovf_o,
    input  logic              er_valid_i,
    input  logic [BLK_W-1:0]  er_blk_i,
    output logic              er_pass_o,
    output logic              er_reject_o
);

    logic             clr;
    logic             wr_en;
    logic [BLK_W-1:0] wr_idx;
    logic             wr_bad;
    logic             scanned;
    logic             er_bad;

    bbscan_walker #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .PAGE_BITS  (PAGE_BITS),
        .COL_W      (COL_W),
        .MARKER_COL (MARKER_COL),
        .DATA_W     (DATA_W)
    ) walker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (scan_start_i),
        .busy_o      (scan_busy_o),
        .done_o      (scan_done_o),
        .scanned_o   (scanned),
        .req_valid_o (rd_req_valid_o),
        .req_ready_i (rd_req_ready_i),
        .req_row_o   (rd_req_row_o),
        .req_col_o   (rd_req_col_o),
        .rsp_valid_i (rd_rsp_valid_i),
        .rsp_data_i  (rd_rsp_data_i),
        .rsp_err_i   (rd_rsp_err_i),
        .clr_o       (clr),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_bad_o    (wr_bad)
    );

    bbscan_bitmap #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) bitmap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_bad_i (wr_bad),
        .lk_idx_i (lk_blk_i),
        .lk_bad_o (lk_bad_o),
        .er_idx_i (er_blk_i),
        .er_bad_o (er_bad)
    );

    bbscan_tally #(
        .MAX_BAD (MAX_BAD)
    ) tally_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .inc_i   (wr_en && wr_bad),
        .count_o (bad_count_o),
        .ovf_o   (bad_ovf_o)
    );

    // Erase guard: forward only for a known-good block of a finished scan.
    always_comb begin
        er_pass_o   = er_valid_i && scanned && !scan_busy_o && !er_bad;
        er_reject_o = er_valid_i && !er_pass_o;
    end

endmodule

// File: rtl/bbscan_chk.sv
// Module: bbscan_chk
// Protocol and invariant checks for bbscan_top, attached by bind.
// Assumes: reset is synchronous and active low.
module bbscan_chk #(
    parameter int ROW_W   = 17,
    parameter int CNT_W   = 6,
    parameter int MAX_BAD = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_busy_o,
    input logic             scan_done_o,
    input logic             rd_req_valid_o,
    input logic             rd_req_ready_i,
    input logic [ROW_W-1:0] rd_req_row_o,
    input logic [CNT_W-1:0] bad_count_o,
    input logic             bad_ovf_o,
    input logic             er_valid_i,
    input logic             er_pass_o,
    input logic             er_reject_o
);

    // R2: an unaccepted request stays valid with a steady row.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_row_o));

    // R2: requests only appear during a scan.
    a_r2_req_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o |-> scan_busy_o);

    // R6: count never passes the limit; overflow implies a full count.
    a_r6_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        bad_count_o <= CNT_W'(MAX_BAD));
    a_r6_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ovf_o |-> bad_count_o == CNT_W'(MAX_BAD));

    // R7: done is a single-cycle pulse and arrives with busy low.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |=> !scan_done_o);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |-> !scan_busy_o);

    // R8: pass and reject are exclusive and need a request.
    a_r8_er_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({er_pass_o, er_reject_o}) && ((er_pass_o || er_reject_o) == er_valid_i));

    // R9: nothing passes while a scan runs.
    a_r9_no_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy_o |-> !er_pass_o);

endmodule

bind bbscan_top bbscan_chk #(
    .ROW_W   (ROW_W),
    .CNT_W   (CNT_W),
    .MAX_BAD (MAX_BAD)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .scan_busy_o    (scan_busy_o),
    .scan_done_o    (scan_done_o),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_row_o   (rd_req_row_o),
    .bad_count_o    (bad_count_o),
    .bad_ovf_o      (bad_ovf_o),
    .er_valid_i     (er_valid_i),
    .er_pass_o      (er_pass_o),
    .er_reject_o    (er_reject_o)
);

// File: tb/bbscan_top_tb_top.sv
// Bench for bbscan_top: a random-latency sequencer model, seeded random bad
// maps, and directed corners (edge blocks, exactly-at-limit, over-limit).
module bbscan_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 2048;
    localparam int BW   = 11;
    localparam int RW   = 17;
    localparam int CW   = 12;
    localparam int CNTW = 6;
    localparam int MAXB = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scan_start = 1'b0;
    logic            scan_busy, scan_done;
    logic            rd_req_valid, rd_req_ready;
    logic [RW-1:0]   rd_req_row;
    logic [CW-1:0]   rd_req_col;
    logic            rd_rsp_valid, rd_rsp_err;
    logic [7:0]      rd_rsp_data;
    logic [BW-1:0]   lk_blk, main_blk, probe_blk;
    logic            probe_on;
    logic            lk_bad;
    logic [CNTW-1:0] bad_count;
    logic            bad_ovf;
    logic            er_valid = 1'b0;
    logic [BW-1:0]   er_blk = '0;
    logic            er_pass, er_reject;

    bit       exp_bad [NB];
    bit       use_err [NB];
    bit [7:0] mark    [NB];
    int checks = 0;
    int errors = 0;
    int exp_req_blk = 0;
    int probe_left = 0;
    int probe_stage = 0;

    assign lk_blk = probe_on ? probe_blk : main_blk;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bbscan_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .scan_start_i   (scan_start),
        .scan_busy_o    (scan_busy),
        .scan_done_o    (scan_done),
        .rd_req_valid_o (rd_req_valid),
        .rd_req_ready_i (rd_req_ready),
        .rd_req_row_o   (rd_req_row),
        .rd_req_col_o   (rd_req_col),
        .rd_rsp_valid_i (rd_rsp_valid),
        .rd_rsp_data_i  (rd_rsp_data),
        .rd_rsp_err_i   (rd_rsp_err),
        .lk_blk_i       (lk_blk),
        .lk_bad_o       (lk_bad),
        .bad_count_o    (bad_count),
        .bad_ovf_o      (bad_ovf),
        .er_valid_i     (er_valid),
        .er_blk_i       (er_blk),
        .er_pass_o      (er_pass),
        .er_reject_o    (er_reject)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int k);
        return (k > MAXB) ? MAXB : k;
    endfunction

    function automatic bit exp_ovf(input int k);
        return k > MAXB;
    endfunction

    // Sequencer model: random ready, random response latency, order check.
    initial begin : seq_model
        bit pending;
        int lat;
        int cap;
        pending = 0; lat = 0; cap = 0;
        rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = '0; rd_rsp_err = 0;
        probe_on = 0; probe_blk = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 0;
            rd_rsp_err   = 0;
            if (probe_on) begin
                if (probe_stage == 0) begin
                    chk(lk_bad == 1'b0, "R11 lookup before write", lk_bad, 0);
                    probe_stage = 1;
                end else begin
                    chk(lk_bad == 1'b1, "R11 lookup after write", lk_bad, 1);
                    probe_on = 0;
                end
            end
            if (pending) begin
                rd_req_ready = 0;
                if (lat == 0) begin
                    rd_rsp_valid = 1;
                    rd_rsp_data  = mark[cap];
                    rd_rsp_err   = use_err[cap];
                    pending      = 0;
                    if (exp_bad[cap] && !probe_on && probe_left > 0) begin
                        probe_blk   = BW'(cap);
                        probe_on    = 1;
                        probe_stage = 0;
                        probe_left--;
                    end
                end else begin
                    lat--;
                end
            end else begin
                rd_req_ready = 1'($urandom_range(0, 1));
                if (rd_req_valid && rd_req_ready) begin
                    chk(rd_req_row == RW'(exp_req_blk << 6), "R2 request row",
                        int'(rd_req_row), exp_req_blk << 6);
                    chk(rd_req_col == CW'(2048), "R2 request column", int'(rd_req_col), 2048);
                    cap = int'(rd_req_row >> 6);
                    exp_req_blk++;
                    pending = 1;
                    lat = $urandom_range(0, 3);
                end
            end
        end
    end

    task automatic set_bad(input int b, input int n);
        exp_bad[b] = 1;
        if (n % 5 == 4) begin
            use_err[b] = 1;
            mark[b]    = 8'($urandom_range(1, 255));
        end else begin
            mark[b] = 8'h00;
        end
    endtask

    task automatic build_map(input int k);
        int n;
        for (int b = 0; b < NB; b++) begin
            exp_bad[b] = 0;
            use_err[b] = 0;
            mark[b]    = 8'($urandom_range(1, 255));
        end
        mark[1] = 8'h01;
        mark[2] = 8'h80;
        set_bad(0, 0);
        set_bad(NB - 1, 1);
        n = 2;
        while (n < k) begin
            int b;
            b = $urandom_range(3, NB - 2);
            if (!exp_bad[b]) begin
                set_bad(b, n);
                n++;
            end
        end
    endtask

    task automatic run_scan(input int k, input bit mid);
        int n;
        build_map(k);
        exp_req_blk = 0;
        probe_left  = 3;
        @(negedge clk);
        scan_start = 1;
        @(negedge clk);
        scan_start = 0;
        chk(scan_busy == 1'b1, "R7 busy after start", scan_busy, 1);
        if (mid) begin
            repeat (40) @(negedge clk);
            er_valid = 1;
            er_blk   = BW'(5);
            #1;
            chk(er_reject == 1'b1 && er_pass == 1'b0, "R9 erase during scan", er_pass, 0);
            @(negedge clk);
            er_valid   = 0;
            scan_start = 1;
            @(negedge clk);
            scan_start = 0;
        end
        n = 0;
        while (!scan_done && n < 60000) begin
            @(negedge clk);
            n++;
        end
        chk(scan_done == 1'b1, "R7 done seen", scan_done, 1);
        chk(scan_busy == 1'b0, "R7 busy low at done", scan_busy, 0);
        chk(exp_req_blk == NB, "R2 R10 request count", exp_req_blk, NB);
        chk(int'(bad_count) == exp_count(k), "R6 bad count", int'(bad_count), exp_count(k));
        chk(bad_ovf == exp_ovf(k), "R6 overflow flag", bad_ovf, int'(exp_ovf(k)));
        @(negedge clk);
        chk(scan_done == 1'b0, "R7 done single pulse", scan_done, 0);
    endtask

    task automatic verify_table();
        for (int b = 0; b < NB; b++) begin
            main_blk = BW'(b);
            @(negedge clk);
            if (use_err[b])
                chk(lk_bad == exp_bad[b], "R4 R5 error verdict", lk_bad, int'(exp_bad[b]));
            else
                chk(lk_bad == exp_bad[b], "R3 R5 marker verdict", lk_bad, int'(exp_bad[b]));
        end
        for (int i = 0; i < 66; i++) begin
            int b;
            b = (i == 0) ? 0 : (i == 1) ? NB - 1 : $urandom_range(0, NB - 1);
            er_valid = 1;
            er_blk   = BW'(b);
            #1;
            chk(er_pass == !exp_bad[b], "R8 erase pass", er_pass, int'(!exp_bad[b]));
            chk(er_reject == exp_bad[b], "R8 erase reject", er_reject, int'(exp_bad[b]));
            @(negedge clk);
        end
        er_valid = 0;
        #1;
        chk(er_pass == 1'b0 && er_reject == 1'b0, "R8 no request", er_pass, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned s;
        s = $urandom(32'h5EED1);
        main_blk = '0;
        repeat (3) @(negedge clk);
        chk(scan_busy == 1'b0 && scan_done == 1'b0, "R1 idle in reset", scan_busy, 0);
        rst_n = 1;
        @(negedge clk);
        chk(rd_req_valid == 1'b0, "R1 no request", rd_req_valid, 0);
        chk(bad_count == '0 && bad_ovf == 1'b0, "R1 count clear", int'(bad_count), 0);
        er_valid = 1;
        er_blk   = BW'(7);
        #1;
        chk(er_pass == 1'b0 && er_reject == 1'b1, "R9 erase before scan", er_pass, 0);
        @(negedge clk);
        er_valid = 0;

        run_scan(25, 1);
        verify_table();
        run_scan(60, 0);
        verify_table();
        run_scan(40, 0);
        verify_table();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule